// File: doc/BRIEF.md
# Two-Channel Triggered Logic Capture

This block watches two single-bit digital signals and records a fixed-length snapshot of both once a chosen trigger condition is seen. Both probe inputs are asynchronous to the block clock, so each one passes through a two-flop synchroniser before any decision is made. The host picks a trigger condition and an 8-bit pacing value, then pulses `arm`. The block waits in the armed state until the trigger condition holds. It then stores 96 two-bit samples into an internal record, spaced by the pacing value, and raises `done`.

Five trigger conditions exist. The capture can start at once, or it can wait for a low-to-high or a high-to-low change on either channel. Once armed, the block cannot be stopped by the host. Only the trigger ends the wait. Mode and pacing are latched when the block is armed, so the host may change its configuration lines freely while a capture runs. After `done` rises, the host reads the record one entry at a time through an index-addressed read port.

Top module: `dual_probe_capture`

## Requirements
- R1: After reset, `armed`, `capturing` and `done` are all low.
- R2: An `arm` pulse while the block is idle or done latches `cfg_mode` and `cfg_delay`. On the next cycle `armed` is high and `done` is low.
- R3: Mode code 0, and the unused codes 5, 6 and 7, trigger on the first armed cycle without waiting for an edge.
- R4: Mode 1 triggers on a rise of channel 1 (probe bit 0), mode 2 on a fall of channel 1, mode 3 on a rise of channel 2 (probe bit 1) and mode 4 on a fall of channel 2. An edge is a difference between the synchronised value and the value one cycle earlier. Edges on the other channel never trigger.
- R5: While armed, `arm` pulses and configuration changes have no effect. The block stays armed until its latched trigger fires.
- R6: Each probe passes through two flops. A sample taken at clock edge k holds the probe values captured at edge k-2.
- R7: Sample 0 is taken on the trigger cycle. With latched delay N, sample i is taken i*(N+1) cycles after it, so N=0 samples on every clock.
- R8: Exactly 96 samples are stored at indices 0 to 95, with channel 1 in bit 0 and channel 2 in bit 1. `capturing` is high from the cycle after the trigger until the last sample is stored, and then `done` goes high.
- R9: During capture, `arm` and configuration changes have no effect. `done` stays high until the next `arm`.
- R10: `rd_data` shows record entry `rd_idx` without a clock delay. Indices 96 and above read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| probe | input | 2 | Asynchronous probe inputs; bit 0 is channel 1, bit 1 is channel 2 |
| cfg_mode | input | 3 | Trigger condition code |
| cfg_delay | input | 8 | Pacing value N; samples are N+1 cycles apart |
| arm | input | 1 | One-cycle pulse that starts an acquisition |
| rd_idx | input | 7 | Record index to read |
| rd_data | output | 2 | Record entry at `rd_idx` |
| armed | output | 1 | Waiting for the trigger |
| capturing | output | 1 | Storing samples after the trigger |
| done | output | 1 | Record complete |

## Verification
The bench checks the two-cycle synchroniser lag. A design with one stage too few or too many stores a record shifted by one position and fails the readback. It triggers channel 2 while channel 1 toggles, so a design that decodes the wrong channel or the wrong edge direction starts early or too late. It pulses `arm` with a new mode and delay while the block is armed and while it is capturing, which exposes a design that aborts, restarts or picks up the new pacing. The largest delay of 255 and delay 0 are both run, which catches an off-by-one in the sample spacing and a counter that wraps. A reserved mode code is used to check that it behaves as an immediate trigger.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int NCH = 2;

  localparam logic [2:0] TRG_NOW  = 3'd0;
  localparam logic [2:0] TRG_A_UP = 3'd1;
  localparam logic [2:0] TRG_A_DN = 3'd2;
  localparam logic [2:0] TRG_B_UP = 3'd3;
  localparam logic [2:0] TRG_B_DN = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_CAPT  = 2'd2,
    ST_DONE  = 2'd3
  } cap_state_e;

  // Decide whether the selected condition holds, given per-channel edges.
  function automatic logic trig_match(input logic [2:0] mode,
                                      input logic [NCH-1:0] rise,
                                      input logic [NCH-1:0] fall);
    case (mode)
      TRG_A_UP: return rise[0];
      TRG_A_DN: return fall[0];
      TRG_B_UP: return rise[1];
      TRG_B_DN: return fall[1];
      default:  return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/dpc_sync.sv
module dpc_sync #(
  parameter int CH     = 2,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] din,
  output logic [CH-1:0] cur,
  output logic [CH-1:0] prev
);
  logic [STAGES-1:0][CH-1:0] pipe;
  logic [CH-1:0]             last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe   <= '0;
      last_q <= '0;
    end else begin
      pipe   <= {pipe[STAGES-2:0], din};
      last_q <= pipe[STAGES-1];
    end
  end

  assign cur  = pipe[STAGES-1];
  assign prev = last_q;
endmodule

// File: rtl/dpc_trigger.sv
module dpc_trigger
  import dpc_pkg::*;
(
  input  logic           en,
  input  logic [2:0]     mode,
  input  logic [NCH-1:0] cur,
  input  logic [NCH-1:0] prev,
  output logic [NCH-1:0] rise,
  output logic [NCH-1:0] fall,
  output logic           hit
);
  for (genvar c = 0; c < NCH; c++) begin : g_edge
    assign rise[c] = cur[c] & ~prev[c];
    assign fall[c] = ~cur[c] & prev[c];
  end

  assign hit = en & trig_match(mode, rise, fall);
endmodule

// File: rtl/dpc_pacer.sv
module dpc_pacer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DLY_W-1:0] dly,
  output logic             tick
);
  logic [DLY_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= dly;
    else if (run)  cnt_q <= (cnt_q == '0) ? dly : cnt_q - 1'b1;
  end

  assign tick = run && (cnt_q == '0);
endmodule

// File: rtl/dpc_buffer.sv
module dpc_buffer #(
  parameter int DEPTH = 96,
  parameter int W     = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && waddr <= TOP) mem[waddr] <= wdata;
  end

  assign rdata = (raddr <= TOP) ? mem[raddr] : '0;
endmodule

// File: rtl/dual_probe_capture.sv
module dual_probe_capture
  import dpc_pkg::*;
#(
  parameter int REC_LEN     = 96,
  parameter int DLY_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = $clog2(REC_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       probe,
  input  logic [2:0]       cfg_mode,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             arm,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_data,
  output logic             armed,
  output logic             capturing,
  output logic             done
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(REC_LEN - 1);

  cap_state_e       st;
  logic [2:0]       mode_q;
  logic [DLY_W-1:0] dly_q;
  logic [IDX_W-1:0] idx_q;

  logic [NCH-1:0]   sync_cur, sync_prev, edge_up, edge_dn;
  logic             trig_hit, tick, wr_en;
  logic [IDX_W-1:0] wr_addr;

  dpc_sync #(.CH(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (probe),
    .cur  (sync_cur),
    .prev (sync_prev)
  );

  dpc_trigger u_trig (
    .en  (st == ST_ARMED),
    .mode(mode_q),
    .cur (sync_cur),
    .prev(sync_prev),
    .rise(edge_up),
    .fall(edge_dn),
    .hit (trig_hit)
  );

  dpc_pacer #(.DLY_W(DLY_W)) u_pace (
    .clk  (clk),
    .rst_n(rst_n),
    .load (trig_hit),
    .run  (st == ST_CAPT),
    .dly  (dly_q),
    .tick (tick)
  );

  assign wr_en   = trig_hit | tick;
  assign wr_addr = (st == ST_ARMED) ? '0 : idx_q;

  dpc_buffer #(.DEPTH(REC_LEN), .W(NCH)) u_buf (
    .clk  (clk),
    .we   (wr_en),
    .waddr(wr_addr),
    .wdata(sync_cur),
    .raddr(rd_idx),
    .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      mode_q <= TRG_NOW;
      dly_q  <= '0;
      idx_q  <= '0;
    end else begin
      case (st)
        ST_IDLE, ST_DONE: begin
          if (arm) begin
            mode_q <= cfg_mode;
            dly_q  <= cfg_delay;
            st     <= ST_ARMED;
          end
        end
        ST_ARMED: begin
          if (trig_hit) begin
            idx_q <= IDX_W'(1);
            st    <= ST_CAPT;
          end
        end
        ST_CAPT: begin
          if (tick) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST) st <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign armed     = (st == ST_ARMED);
  assign capturing = (st == ST_CAPT);
  assign done      = (st == ST_DONE);
endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
  parameter int DLY_W   = 8,
  parameter int IDX_W   = 7,
  parameter int REC_LEN = 96
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm,
  input logic             armed,
  input logic             capturing,
  input logic             done,
  input logic             trig_hit,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_addr,
  input logic [2:0]       mode_q,
  input logic [DLY_W-1:0] dly_q,
  input logic [1:0]       cur,
  input logic [1:0]       prev
);
  a_r2_arm_enters: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !capturing && arm) |=> armed);

  a_r3_now_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && (mode_q == 3'd0 || mode_q > 3'd4)) |-> trig_hit);

  a_r4_ch1_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit && mode_q == 3'd1) |-> (cur[0] && !prev[0]));

  a_r4_ch2_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit && mode_q == 3'd4) |-> (!cur[1] && prev[1]));

  a_r5_hold_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !trig_hit) |=> armed);

  a_r7_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dly_q != '0) |=> !wr_en);

  a_r7_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (capturing && dly_q == '0) |-> wr_en);

  a_r8_last_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(wr_en) && $past(wr_addr) == IDX_W'(REC_LEN - 1)));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    capturing |=> ($stable(mode_q) && $stable(dly_q)));
endmodule

bind dual_probe_capture dpc_checker #(
  .DLY_W(DLY_W), .IDX_W(IDX_W), .REC_LEN(REC_LEN)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .arm      (arm),
  .armed    (armed),
  .capturing(capturing),
  .done     (done),
  .trig_hit (trig_hit),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .mode_q   (mode_q),
  .dly_q    (dly_q),
  .cur      (sync_cur),
  .prev     (sync_prev)
);

// File: tb/dual_probe_capture_tb.sv
module dual_probe_capture_tb;
  localparam int REC = 96;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] probe = 2'b00;
  logic [2:0] cfg_mode = 3'd0;
  logic [7:0] cfg_delay = 8'd0;
  logic       arm = 1'b0;
  logic [6:0] rd_idx = 7'd0;
  logic [1:0] rd_data;
  logic       armed, capturing, done;

  int n_tests = 0;
  int n_fail  = 0;
  int pat_sel = 0;
  int drv_cyc = 0;

  always #10 clk = ~clk;

  dual_probe_capture u_dut (
    .clk(clk), .rst_n(rst_n), .probe(probe), .cfg_mode(cfg_mode),
    .cfg_delay(cfg_delay), .arm(arm), .rd_idx(rd_idx), .rd_data(rd_data),
    .armed(armed), .capturing(capturing), .done(done)
  );

  // Reference model: 0 idle, 1 waiting, 2 recording, 3 finished.
  int         m_st;
  logic [2:0] m_mode;
  int         m_dly;
  longint     m_cyc, m_t0;
  logic [1:0] hist[$];
  logic [1:0] m_rec [REC];

  function automatic bit m_fires(logic [2:0] md, logic [1:0] c, logic [1:0] p);
    if (md == 3'd1) return c[0] == 1'b1 && p[0] == 1'b0;
    if (md == 3'd2) return c[0] == 1'b0 && p[0] == 1'b1;
    if (md == 3'd3) return c[1] == 1'b1 && p[1] == 1'b0;
    if (md == 3'd4) return c[1] == 1'b0 && p[1] == 1'b1;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0;
      m_cyc = 0;
      hist = '{2'b00, 2'b00, 2'b00, 2'b00};
    end else begin
      logic [1:0] now_v, old_v;
      longint el;
      m_cyc++;
      hist.push_front(probe);
      if (hist.size() > 4) void'(hist.pop_back());
      now_v = hist[2];
      old_v = hist[3];
      if (m_st == 0 || m_st == 3) begin
        if (arm) begin m_mode = cfg_mode; m_dly = int'(cfg_delay); m_st = 1; end
      end else if (m_st == 1) begin
        if (m_fires(m_mode, now_v, old_v)) begin
          m_t0 = m_cyc; m_rec[0] = now_v; m_st = 2;
        end
      end else begin
        el = m_cyc - m_t0;
        if (el % (m_dly + 1) == 0) begin
          m_rec[el / (m_dly + 1)] = now_v;
          if (el / (m_dly + 1) == REC - 1) m_st = 3;
        end
      end
    end
  end

  function automatic logic [1:0] pat(int sel, int c);
    case (sel)
      1: return {c[2], c[0]};
      2: return {1'b0, 1'(c / 5 % 2)};
      3: return 2'((c * 7) ^ (c >> 2));
      4: return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Compare flags against the model at the falling edge, then drive inputs.
  task automatic step(bit a);
    @(negedge clk);
    chk("R8 flags armed", armed, int'(m_st == 1));
    chk("R8 flags capturing", capturing, int'(m_st == 2));
    chk("R9 flags done", done, int'(m_st == 3));
    probe = pat(pat_sel, drv_cyc);
    drv_cyc++;
    arm = a;
  endtask

  task automatic run_to_done();
    for (int g = 0; g < 40000 && m_st != 3; g++) step(1'b0);
    chk("R8 record finished", done, 1);
  endtask

  task automatic readback(string req);
    for (int i = 0; i < REC; i++) begin
      rd_idx = 7'(i);
      #1;
      chk(req, rd_data, m_rec[i]);
    end
    rd_idx = 7'd100;
    #1;
    chk("R10 out-of-range index", rd_data, 0);
  endtask

  task automatic start(logic [2:0] md, logic [7:0] dl, int ps);
    cfg_mode = md;
    cfg_delay = dl;
    pat_sel = ps;
    step(1'b1);
    step(1'b0);
    chk("R2 armed after pulse", armed, 1);
    chk("R2 done cleared", done, 0);
  endtask

  initial begin
    #(200000 * 20);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) step(1'b0);
    chk("R1 reset armed", armed, 0);
    chk("R1 reset capturing", capturing, 0);
    chk("R1 reset done", done, 0);
    @(negedge clk) rst_n = 1'b1;
    for (int i = 0; i < 8; i++) step(1'b0);

    // R3 immediate, R6 lag, R7 delay 0
    start(3'd0, 8'd0, 3);
    run_to_done();
    readback("R6 immediate record");

    // R4 channel 1 rising, delay 3
    start(3'd1, 8'd3, 3);
    run_to_done();
    readback("R4 ch1 rise record");

    // R4 channel 1 falling, delay 0
    start(3'd2, 8'd0, 1);
    run_to_done();
    readback("R4 ch1 fall record");

    // R4/R5 channel 2 rising while channel 1 toggles; re-arm ignored
    pat_sel = 4;
    for (int i = 0; i < 6; i++) step(1'b0);
    start(3'd3, 8'd2, 2);
    for (int i = 0; i < 30; i++) step(1'b0);
    chk("R4 no trigger from other channel", armed, 1);
    cfg_mode = 3'd0;
    cfg_delay = 8'd7;
    step(1'b1);
    for (int i = 0; i < 5; i++) step(1'b0);
    chk("R5 still armed after pulse", armed, 1);
    pat_sel = 4;
    run_to_done();
    readback("R5 record keeps first config");

    // R7/R9 channel 2 falling, delay 255, disturbances during capture
    start(3'd4, 8'd255, 1);
    for (int g = 0; g < 100 && m_st != 2; g++) step(1'b0);
    chk("R9 capture started", capturing, 1);
    cfg_mode = 3'd0;
    cfg_delay = 8'd0;
    step(1'b1);
    step(1'b0);
    chk("R9 arm ignored in capture", capturing, 1);
    run_to_done();
    readback("R7 delay 255 record");
    for (int i = 0; i < 20; i++) step(1'b0);
    chk("R9 done sticky", done, 1);

    // R3 reserved code behaves as immediate
    start(3'd6, 8'd1, 3);
    run_to_done();
    readback("R3 reserved code record");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule